// File: doc/BRIEF.md
# Threshold-Qualified Event Counter with Periodic Interrupt

This block counts a per-cycle event quantity that arrives as a small number, from 0 to 6, each clock. In its simplest setting it adds that number to a 40-bit total. With a nonzero threshold it counts cycles instead. A cycle counts when the event quantity reaches the threshold. With the invert bit set, a cycle counts when the quantity stays below the threshold. This turns a per-cycle activity figure into a count of busy cycles or idle cycles.

In sampling mode the counter is preset to a reload period and counts down. When a decrement reaches or passes zero, it emits a one-cycle interrupt pulse and reloads itself. Any overshoot is carried into the reloaded value, so no events are lost. A monitoring agent writes the configuration through a single write strobe. The write restarts counting and discards any pending interrupt. The running value is visible at all times on an output port.

The control is a three-state machine. ST_IDLE does not count. ST_UP accumulates upward. ST_DOWN counts down toward the interrupt. Transitions happen only on a configuration write:
- LOAD_OFF goes to ST_IDLE when the count-enable bit is written 0.
- LOAD_UP goes to ST_UP when count-enable is 1 and sampling is 0.
- LOAD_DOWN goes to ST_DOWN when count-enable is 1 and sampling is 1.
Without a write, every state holds.

Top module: `evt_threshold_counter`

## Requirements
- R1: After reset the count is 0, the interrupt is low, the machine is in ST_IDLE, and no event changes the count until a configuration write enables counting.
- R2: In ST_UP with threshold 0, each enabled cycle adds the raw event quantity (0 to 6) to the count, modulo 2^40.
- R3: In ST_UP with a nonzero threshold and invert 0, each enabled cycle adds 1 when the event quantity is greater than or equal to the threshold, and 0 otherwise.
- R4: With invert 1 and a nonzero threshold, a cycle counts when the event quantity is less than the threshold. With threshold 0, invert has no effect. Over one stimulus sequence, the normal count plus the inverted count equals the number of enabled cycles.
- R5: While the global enable input is low, the count holds and no interrupt is raised.
- R6: A configuration write latches threshold, invert, sampling bit and reload value. It loads the count with the written reload value when the sampling bit is 1, and with 0 otherwise. The event quantity of the write cycle is dropped, and no interrupt pulse follows the write cycle. Counting resumes in the next cycle.
- R7: After a write with count-enable 0, the count holds regardless of events or global enable.
- R8: In ST_DOWN, each enabled cycle subtracts the qualified increment (as defined in R2 to R4) from the count, provided the increment is smaller than the count.
- R9: In ST_DOWN, when the increment is nonzero and is at least the count, the interrupt goes high for exactly the next cycle. The count becomes reload minus the overshoot (increment minus count). When the overshoot is not below the reload value, the count becomes the reload value.
- R10: The interrupt is never high except in the cycle after an underflow described in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable; counting stops while low |
| evt_cnt | input | 3 | Event quantity this cycle, 0 to 6 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cnt_en | input | 1 | Written count-enable bit |
| cfg_thresh | input | 3 | Written threshold; 0 selects raw accumulation |
| cfg_inv | input | 1 | Written invert bit for the threshold compare |
| cfg_sample | input | 1 | Written mode bit; 1 selects down-counting with reload |
| cfg_reload | input | 40 | Written reload period |
| count_q | output | 40 | Current counter value |
| irq | output | 1 | One-cycle interrupt pulse after each underflow |

## Verification
The assertions check several properties on every cycle:
- An interrupt appears only after a cycle spent in ST_DOWN with the global enable high and no write.
- No interrupt follows a write.
- The count and the state hold whenever there is no write and counting is disabled.
- An up-count never advances by more than six.
- A qualified compare never yields more than one.

Other behaviour depends on exact values, and only the bench scenarios can show it:
- the carried overshoot after a reload;
- the clamp when the reload is small;
- the complement identity between normal and inverted counts over one event sequence;
- the dropped event in a write cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } pmc_state_e;
endpackage

// File: rtl/pmc_qualify.sv
module pmc_qualify #(
    parameter int EVT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt,
    input  logic [EVT_W-1:0] thr,
    input  logic             inv,
    output logic [EVT_W-1:0] inc
);
    logic hit;

    always_comb begin
        hit = inv ? (evt < thr) : (evt >= thr);
        if (thr == '0) begin
            inc = evt;
        end else begin
            inc = {{(EVT_W-1){1'b0}}, hit};
        end
    end

    // A thresholded compare contributes at most one per cycle.
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr != '0) |-> (inc <= 1));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_cnt_en,
    input  logic       cfg_sample,
    output pmc_state_e state
);
    pmc_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_UP, ST_DOWN: begin
                if (cfg_we) begin
                    if (!cfg_cnt_en)     state_nx = ST_IDLE;
                    else if (cfg_sample) state_nx = ST_DOWN;
                    else                 state_nx = ST_UP;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // The mode changes only through a configuration write.
    assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(state));
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
    import pmc_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int EVT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmc_state_e       state,
    input  logic             glb_en,
    input  logic             cfg_we,
    input  logic             cfg_sample,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic [CNT_W-1:0] reload_q,
    input  logic [EVT_W-1:0] inc,
    output logic [CNT_W-1:0] count_q,
    output logic             irq
);
    localparam logic [CNT_W-1:0] STEP_LIMIT = CNT_W'(6);

    logic [CNT_W-1:0] inc_w;
    logic [CNT_W-1:0] overshoot;
    logic [CNT_W-1:0] refill;
    logic             live;
    logic             underflow;

    always_comb begin
        inc_w     = {{(CNT_W-EVT_W){1'b0}}, inc};
        live      = glb_en && !cfg_we;
        underflow = (inc != '0) && (inc_w >= count_q);
        overshoot = inc_w - count_q;
        refill    = (overshoot < reload_q) ? (reload_q - overshoot) : reload_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            irq     <= 1'b0;
        end else if (cfg_we) begin
            count_q <= cfg_sample ? cfg_reload : '0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (live) begin
                unique case (state)
                    ST_UP:   count_q <= count_q + inc_w;
                    ST_DOWN: begin
                        if (underflow) begin
                            count_q <= refill;
                            irq     <= 1'b1;
                        end else begin
                            count_q <= count_q - inc_w;
                        end
                    end
                    default: count_q <= count_q;
                endcase
            end
        end
    end

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(state == ST_DOWN && glb_en && !cfg_we));
    assert_no_irq_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !irq);
    assert_gated_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !cfg_we) |=> ($stable(count_q) && !irq));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cfg_we) |=> $stable(count_q));
    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UP && !cfg_we) |=> ((count_q - $past(count_q)) <= STEP_LIMIT));
endmodule

// File: rtl/evt_threshold_counter.sv
module evt_threshold_counter
    import pmc_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int EVT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic [EVT_W-1:0] evt_cnt,
    input  logic             cfg_we,
    input  logic             cfg_cnt_en,
    input  logic [EVT_W-1:0] cfg_thresh,
    input  logic             cfg_inv,
    input  logic             cfg_sample,
    input  logic [CNT_W-1:0] cfg_reload,
    output logic [CNT_W-1:0] count_q,
    output logic             irq
);
    logic [EVT_W-1:0] thr_q;
    logic             inv_q;
    logic [CNT_W-1:0] reload_q;
    logic [EVT_W-1:0] inc;
    pmc_state_e       state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q    <= '0;
            inv_q    <= 1'b0;
            reload_q <= '0;
        end else if (cfg_we) begin
            thr_q    <= cfg_thresh;
            inv_q    <= cfg_inv;
            reload_q <= cfg_reload;
        end
    end

    pmc_qualify #(.EVT_W(EVT_W)) u_qualify (
        .clk (clk),
        .rst_n (rst_n),
        .evt (evt_cnt),
        .thr (thr_q),
        .inv (inv_q),
        .inc (inc)
    );

    pmc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_cnt_en (cfg_cnt_en),
        .cfg_sample (cfg_sample),
        .state      (state)
    );

    pmc_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .glb_en     (glb_en),
        .cfg_we     (cfg_we),
        .cfg_sample (cfg_sample),
        .cfg_reload (cfg_reload),
        .reload_q   (reload_q),
        .inc        (inc),
        .count_q    (count_q),
        .irq        (irq)
    );
endmodule

// File: tb/evt_threshold_counter_bench.sv
module evt_threshold_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic [2:0]  evt_cnt = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_cnt_en = 1'b0;
    logic [2:0]  cfg_thresh = '0;
    logic        cfg_inv = 1'b0;
    logic        cfg_sample = 1'b0;
    logic [39:0] cfg_reload = '0;
    logic [39:0] count_q;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state: mode 0 idle, 1 up, 2 down.
    longint m_cnt = 0;
    bit     m_irq = 0;
    int     m_mode = 0;
    int     m_thr = 0;
    bit     m_inv = 0;
    longint m_rel = 0;

    always #10 clk = ~clk;

    evt_threshold_counter u_evt_threshold_counter (
        .clk (clk), .rst_n (rst_n), .glb_en (glb_en), .evt_cnt (evt_cnt),
        .cfg_we (cfg_we), .cfg_cnt_en (cfg_cnt_en), .cfg_thresh (cfg_thresh),
        .cfg_inv (cfg_inv), .cfg_sample (cfg_sample), .cfg_reload (cfg_reload),
        .count_q (count_q), .irq (irq)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_update();
        int q;
        longint mask = (longint'(1) << 40) - 1;
        m_irq = 0;
        if (cfg_we) begin
            m_thr  = int'(cfg_thresh);
            m_inv  = cfg_inv;
            m_rel  = longint'(cfg_reload);
            m_cnt  = cfg_sample ? m_rel : 0;
            m_mode = !cfg_cnt_en ? 0 : (cfg_sample ? 2 : 1);
        end else if (glb_en && m_mode != 0) begin
            if (m_thr == 0)  q = int'(evt_cnt);
            else if (m_inv)  q = (int'(evt_cnt) < m_thr) ? 1 : 0;
            else             q = (int'(evt_cnt) >= m_thr) ? 1 : 0;
            if (m_mode == 1) begin
                m_cnt = (m_cnt + q) & mask;
            end else if (q != 0 && q >= m_cnt) begin
                longint ov = q - m_cnt;
                m_cnt = (ov < m_rel) ? m_rel - ov : m_rel;
                m_irq = 1;
            end else begin
                m_cnt = m_cnt - q;
            end
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check({tag, " count"}, longint'(count_q), m_cnt);
        check({tag, " irq"}, longint'(irq), longint'(m_irq));
    endtask

    task automatic run(input bit ge, input int ev, input string tag);
        glb_en  = ge;
        evt_cnt = 3'(ev);
        step(tag);
    endtask

    task automatic configure(input bit en, input int thr, input bit inv, input bit smp,
                             input longint rel, input string tag);
        cfg_we = 1'b1; cfg_cnt_en = en; cfg_thresh = 3'(thr);
        cfg_inv = inv; cfg_sample = smp; cfg_reload = 40'(rel);
        evt_cnt = 3'd5; glb_en = 1'b1;
        step(tag);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pat[10] = '{0, 1, 2, 3, 0, 6, 2, 1, 0, 4};
        longint cnt_a;
        longint cnt_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, then idle ignores events
        check("R1 reset count", longint'(count_q), 0);
        check("R1 reset irq", longint'(irq), 0);
        for (int i = 0; i < 4; i++) run(1'b1, 6, "R1");

        // R2: raw accumulation, event in write cycle dropped (R6)
        configure(1'b1, 0, 1'b0, 1'b0, 0, "R6");
        for (int i = 0; i <= 6; i++) run(1'b1, i, "R2");

        // R3: threshold 2 normal compare
        configure(1'b1, 2, 1'b0, 1'b0, 0, "R6");
        foreach (pat[i]) run(1'b1, pat[i], "R3");
        cnt_a = longint'(count_q);
        check("R3 total", cnt_a, 5);

        // R4: same sequence inverted; sum equals cycles
        configure(1'b1, 2, 1'b1, 1'b0, 0, "R6");
        foreach (pat[i]) run(1'b1, pat[i], "R4");
        cnt_b = longint'(count_q);
        check("R4 complement", cnt_a + cnt_b, 10);
        // R4: invert ignored at threshold 0
        configure(1'b1, 0, 1'b1, 1'b0, 0, "R6");
        run(1'b1, 4, "R4"); run(1'b1, 3, "R4");
        check("R4 raw with invert", longint'(count_q), 7);

        // R5: global enable low holds
        for (int i = 0; i < 3; i++) run(1'b0, 6, "R5");

        // R7: count-enable off holds
        configure(1'b0, 0, 1'b0, 1'b0, 0, "R6");
        for (int i = 0; i < 3; i++) run(1'b1, 6, "R7");

        // R8/R9: down counting with carried overshoot
        configure(1'b1, 0, 1'b0, 1'b1, 5, "R6");
        run(1'b1, 2, "R8"); run(1'b1, 2, "R8"); run(1'b1, 2, "R9");
        check("R9 carried reload", longint'(count_q), 4);
        run(1'b1, 0, "R10"); run(1'b1, 4, "R9"); run(1'b1, 1, "R8");
        run(1'b0, 6, "R5");
        // R9: exact hit at zero, then many sampling rounds
        for (int i = 0; i < 12; i++) run(1'b1, (i % 7), "R9");

        // R9: clamp when overshoot not below reload
        configure(1'b1, 0, 1'b0, 1'b1, 2, "R6");
        run(1'b1, 6, "R9"); run(1'b1, 6, "R9"); run(1'b1, 0, "R10");

        // R9: reload 0 -> pulse on every event
        configure(1'b1, 0, 1'b0, 1'b1, 0, "R6");
        run(1'b1, 1, "R9"); run(1'b1, 3, "R9"); run(1'b1, 0, "R10");

        // Idle-cycle sampling: threshold 1 inverted
        configure(1'b1, 1, 1'b1, 1'b1, 3, "R6");
        for (int i = 0; i < 10; i++) run(1'b1, (i % 3 == 0) ? 0 : 2, "R4");

        // R6: write during an underflow cycle suppresses the pulse
        configure(1'b1, 0, 1'b0, 1'b1, 1, "R6");
        evt_cnt = 3'd6;
        configure(1'b1, 0, 1'b0, 1'b1, 1, "R6");
        run(1'b1, 0, "R6");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule